// File: doc/BRIEF.md
# Capture-Compare Timer with PWM

This block is a 16-bit counter peripheral. The counter advances at a rate taken from the system clock through a divider of 2, 4 or 8, or from edges on an external clock pin. Two capture pins each copy the running count into a capture register and raise a status flag when the chosen edge arrives. A compare output pin carries either a repeating pulse-width waveform or a single pulse started by capture pin A.

Software reaches the block through a byte-wide register port. Reads return data combinationally from the address. A read strobe or a write strobe applied to an address triggers any side effect of that access at the next clock edge. Each status flag is cleared by a two-step sequence. Software first reads the status byte while the flag is set. It then accesses the low byte of the register that belongs to that flag.

Top module: `ccp_timer`

## Requirements
- R1: After reset the control byte, the status byte, the count and the capture registers read zero, and `cmp_out` is low.
- R2: Control bits [3:2] select the count rate: 00 advances the counter once every 4 clocks, 01 once every 2 clocks, and 10 once every 8 clocks.
- R3: With control bits [3:2] = 11, the counter advances on external pin edges seen after a two-flop synchronizer. Control bit 0 set to 1 counts rising edges and set to 0 counts falling edges. When the block is built without an external pin (`HAS_EXT_PIN` = 0), the counter holds its value in this setting.
- R4: A selected edge on capture pin A (control bit 7: 1 rising, 0 falling) or capture pin B (control bit 1: same coding) copies the current count into that pin's capture register and sets status bit 7 (A) or bit 6 (B). An edge of the other polarity captures nothing.
- R5: A capture flag is cleared only when two steps occur in order. First, the status byte (address 1) is read with the read strobe while the flag is set. Then the flag's capture low byte (address 3 for A, 5 for B) is read or written. An access to the low byte with no such prior status read, or an access to the high byte, leaves the flag set.
- R6: When the counter steps from FFFFh to 0000h, status bit 5 is set. It is cleared by a status read followed by an access to the count low byte (address 11). A PWM reload does not set this bit.
- R7: PWM mode (control bit 4) reloads the counter to zero on the count step at which the count is at or above compare B. `cmp_out` is high while the count is below compare A. Every reload sets status bit 7.
- R8: One-pulse mode (control bit 5 with bit 4 clear) makes an accepted edge on capture pin A reset the counter to zero and drive `cmp_out` high. The output stays high until the counter steps onto the compare A value. Trigger edges that arrive while the pulse is high are ignored.
- R9: When control bits 4 and 5 are both set, PWM behaviour applies and one-pulse behaviour is suppressed.
- R10: Byte addresses are: 0 control, 1 status, 2/3 capture A high/low, 4/5 capture B high/low, 6/7 compare A high/low, 8/9 compare B high/low, 10/11 count high/low. Control bit 6 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cap_a_pin | input | 1 | Capture pin A, also the one-pulse trigger |
| cap_b_pin | input | 1 | Capture pin B |
| ext_clk_pin | input | 1 | External count clock |
| cmp_out | output | 1 | Compare output (PWM or single pulse) |

## Verification
The count rate is tried with each divider over a fixed 40-cycle window, and with runs of external pulses under both edge polarities. This separates the three divide ratios and separates rising-edge counting from falling-edge counting. Captures are taken with the counter stopped, so the latched value is known exactly. Each pin also receives an edge of the wrong polarity, which must capture nothing. The PWM waveform is checked by counting its high cycles over an exact number of periods and by tracking the peak count value; this detects a wrong duty cycle or a wrong reload point. A one-pulse run with a second trigger in the middle of the pulse shows whether that trigger is ignored or restarts the pulse. The flag-clear sequences are driven with steps missing or out of order, so that a missing guard on either step shows up.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int unsigned TMR_W  = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CK_DIV4 = 2'b00,
    CK_DIV2 = 2'b01,
    CK_DIV8 = 2'b10,
    CK_EXT  = 2'b11
  } clk_sel_e;

  typedef struct packed {
    logic     cap_a_rise;
    logic     spare;
    logic     pulse_en;
    logic     pwm_en;
    clk_sel_e src;
    logic     cap_b_rise;
    logic     ext_rise;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CAPA_H = 4'd2;
  localparam logic [ADDR_W-1:0] A_CAPA_L = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAPB_H = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAPB_L = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMPA_H = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMPA_L = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMPB_H = 4'd8;
  localparam logic [ADDR_W-1:0] A_CMPB_L = 4'd9;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 4'd10;
  localparam logic [ADDR_W-1:0] A_CNT_L  = 4'd11;

  localparam logic [BYTE_W-1:0] CTRL_WMASK = 8'hBF;

  // Divider phase mask: a tick fires when all masked phase bits are one.
  function automatic logic [2:0] div_mask(input clk_sel_e s);
    case (s)
      CK_DIV2: return 3'b001;
      CK_DIV4: return 3'b011;
      CK_DIV8: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic edge_hit(input logic now, input logic prev, input logic rise);
    return rise ? (now & ~prev) : (~now & prev);
  endfunction

  function automatic logic pwm_level(input logic [TMR_W-1:0] cnt, input logic [TMR_W-1:0] cmp);
    return cnt < cmp;
  endfunction

  function automatic logic [BYTE_W-1:0] byte_of(input logic [TMR_W-1:0] v, input logic hi);
    return hi ? v[TMR_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/ccp_edge_sync.sv
module ccp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_i,
  output logic hit_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], pin_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign hit_o = ccp_pkg::edge_hit(sync_q[LAST], prev_q, rise_i);
endmodule

// File: rtl/ccp_prescale.sv
module ccp_prescale
  import ccp_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e src_i,
  input  logic     ext_hit_i,
  output logic     tick_o
);
  localparam int PH_W = 3;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + PH_W'(1);
  end

  assign mask   = div_mask(src_i);
  assign tick_o = (src_i == CK_EXT) ? (ext_hit_i & HAS_EXT)
                                    : ((phase_q & mask) == mask);
endmodule

// File: rtl/ccp_count_core.sv
module ccp_count_core
  import ccp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pwm_i,
  input  logic             pulse_i,
  input  logic             trig_i,
  input  logic [TMR_W-1:0] cmp_a_i,
  input  logic [TMR_W-1:0] cmp_b_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             reload_o,
  output logic             start_o,
  output logic             busy_o,
  output logic             wave_o
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_inc;
  logic             busy_q;
  logic             pulse_mode;

  assign pulse_mode = pulse_i & ~pwm_i;
  assign cnt_inc    = cnt_q + TMR_W'(1);
  assign start_o    = pulse_mode & trig_i & ~busy_q;
  assign reload_o   = pwm_i & tick_i & (cnt_q >= cmp_b_i);
  assign wrap_o     = tick_i & ~reload_o & ~start_o & (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start_o || reload_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (!pulse_mode) begin
      busy_q <= 1'b0;
    end else if (start_o) begin
      busy_q <= 1'b1;
    end else if (busy_q && tick_i && (cnt_inc == cmp_a_i)) begin
      busy_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = busy_q;
  assign wave_o = pwm_i ? pwm_level(cnt_q, cmp_a_i) : busy_q;
endmodule

// File: rtl/ccp_timer.sv
module ccp_timer
  import ccp_pkg::*;
#(
  parameter bit HAS_EXT_PIN = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cap_a_pin,
  input  logic              cap_b_pin,
  input  logic              ext_clk_pin,
  output logic              cmp_out
);
  localparam int NUM_IN   = 3;  // 0: capture A, 1: capture B, 2: external clock
  localparam int NUM_CAP  = 2;
  localparam int NUM_FLAG = 3;  // 0: capture A, 1: capture B, 2: wrap

  ctrl_t            ctrl_q;
  logic [TMR_W-1:0] cmp_a_q, cmp_b_q, cnt;
  logic [TMR_W-1:0] cap_q [NUM_CAP];
  logic [TMR_W-1:0] cap_a_q, cap_b_q;
  logic [NUM_IN-1:0] pin_vec, rise_vec, hit;
  logic              tick, wrap_evt, reload_evt, start_evt, pulse_busy;
  logic              pwm_on;
  clk_sel_e          src_sel;

  logic [NUM_FLAG-1:0] flag_q, arm_q, flag_set, lo_acc, flag_clr;
  logic                bus_acc, stat_rd;

  assign pin_vec  = {ext_clk_pin, cap_b_pin, cap_a_pin};
  assign rise_vec = {ctrl_q.ext_rise, ctrl_q.cap_b_rise, ctrl_q.cap_a_rise};
  assign pwm_on   = ctrl_q.pwm_en;
  assign src_sel  = ctrl_q.src;

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
    ccp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_vec[gi]),
      .rise_i (rise_vec[gi]),
      .hit_o  (hit[gi])
    );
  end

  ccp_prescale #(.HAS_EXT(HAS_EXT_PIN)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_sel),
    .ext_hit_i (hit[2]),
    .tick_o    (tick)
  );

  ccp_count_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .pwm_i    (ctrl_q.pwm_en),
    .pulse_i  (ctrl_q.pulse_en),
    .trig_i   (hit[0]),
    .cmp_a_i  (cmp_a_q),
    .cmp_b_i  (cmp_b_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap_evt),
    .reload_o (reload_evt),
    .start_o  (start_evt),
    .busy_o   (pulse_busy),
    .wave_o   (cmp_out)
  );

  for (genvar gc = 0; gc < NUM_CAP; gc++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_q[gc] <= '0;
      else if (hit[gc]) cap_q[gc] <= cnt;
    end
  end
  assign cap_a_q = cap_q[0];
  assign cap_b_q = cap_q[1];

  // Flag set sources and the low-byte access that completes each clear.
  assign bus_acc     = bus_rd | bus_wr;
  assign stat_rd     = bus_rd & (bus_addr == A_STAT);
  assign flag_set[0] = hit[0] | reload_evt;
  assign flag_set[1] = hit[1];
  assign flag_set[2] = wrap_evt;
  assign lo_acc[0]   = bus_acc & (bus_addr == A_CAPA_L);
  assign lo_acc[1]   = bus_acc & (bus_addr == A_CAPB_L);
  assign lo_acc[2]   = bus_acc & (bus_addr == A_CNT_L);

  for (genvar gf = 0; gf < NUM_FLAG; gf++) begin : g_flag
    assign flag_clr[gf] = lo_acc[gf] & arm_q[gf];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[gf] <= 1'b0;
        arm_q[gf]  <= 1'b0;
      end else begin
        if (flag_set[gf])      flag_q[gf] <= 1'b1;
        else if (flag_clr[gf]) flag_q[gf] <= 1'b0;
        if (stat_rd)           arm_q[gf]  <= flag_q[gf];
        else if (lo_acc[gf])   arm_q[gf]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:   ctrl_q               <= ctrl_t'(bus_wdata & CTRL_WMASK);
        A_CMPA_H: cmp_a_q[TMR_W-1:BYTE_W] <= bus_wdata;
        A_CMPA_L: cmp_a_q[BYTE_W-1:0]     <= bus_wdata;
        A_CMPB_H: cmp_b_q[TMR_W-1:BYTE_W] <= bus_wdata;
        A_CMPB_L: cmp_b_q[BYTE_W-1:0]     <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = ctrl_q;
      A_STAT:   bus_rdata = {flag_q[0], flag_q[1], flag_q[2], 5'b0};
      A_CAPA_H: bus_rdata = byte_of(cap_a_q, 1'b1);
      A_CAPA_L: bus_rdata = byte_of(cap_a_q, 1'b0);
      A_CAPB_H: bus_rdata = byte_of(cap_b_q, 1'b1);
      A_CAPB_L: bus_rdata = byte_of(cap_b_q, 1'b0);
      A_CMPA_H: bus_rdata = byte_of(cmp_a_q, 1'b1);
      A_CMPA_L: bus_rdata = byte_of(cmp_a_q, 1'b0);
      A_CMPB_H: bus_rdata = byte_of(cmp_b_q, 1'b1);
      A_CMPB_L: bus_rdata = byte_of(cmp_b_q, 1'b0);
      A_CNT_H:  bus_rdata = byte_of(cnt, 1'b1);
      A_CNT_L:  bus_rdata = byte_of(cnt, 1'b0);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ccp_timer_chk.sv
module ccp_timer_chk
  import ccp_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [TMR_W-1:0] cnt,
  input logic [1:0]       cap_hit,
  input logic [TMR_W-1:0] cap_a_q,
  input logic [TMR_W-1:0] cap_b_q,
  input logic [2:0]       flag_q,
  input logic [2:0]       flag_clr,
  input logic             reload_evt,
  input logic             wrap_evt,
  input logic             start_evt,
  input logic             pulse_busy,
  input clk_sel_e         src_sel
);
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src_sel != CK_EXT) |=> (!tick || src_sel != $past(src_sel))); // R2

  AST_NO_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_EXT && src_sel == CK_EXT && !start_evt) |=> $stable(cnt)); // R3

  AST_CAP_A_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit[0] |=> (cap_a_q == $past(cnt))); // R4

  AST_CAP_B_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit[1] |=> (cap_b_q == $past(cnt) && flag_q[1])); // R4

  AST_FLAG_A_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(flag_clr[0])); // R5

  AST_FLAG_B_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[1]) |-> $past(flag_clr[1])); // R5

  AST_WRAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2]) |-> ($past(cnt) == '1)); // R6

  AST_WRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[2]) |-> $past(flag_clr[2])); // R6

  AST_RELOAD_NOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |-> !wrap_evt); // R6

  AST_PWM_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (cnt == '0 && flag_q[0])); // R7

  AST_PULSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !pulse_busy); // R8

  AST_PULSE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (pulse_busy && cnt == '0)); // R8
endmodule

bind ccp_timer ccp_timer_chk #(.HAS_EXT(HAS_EXT_PIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .cnt        (cnt),
  .cap_hit    (hit[1:0]),
  .cap_a_q    (cap_a_q),
  .cap_b_q    (cap_b_q),
  .flag_q     (flag_q),
  .flag_clr   (flag_clr),
  .reload_evt (reload_evt),
  .wrap_evt   (wrap_evt),
  .start_evt  (start_evt),
  .pulse_busy (pulse_busy),
  .src_sel    (src_sel)
);

// File: tb/ccp_timer_tb_top.sv
module ccp_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_s = 1'b0, rd_s = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_n;
  logic       cap_a = 1'b0, cap_b = 1'b0, ext_p = 1'b0;
  logic       out_m, out_n;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  ccp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_s), .bus_rd(rd_s),
    .bus_wdata(wdata), .bus_rdata(rdata), .cap_a_pin(cap_a), .cap_b_pin(cap_b),
    .ext_clk_pin(ext_p), .cmp_out(out_m));

  ccp_timer #(.HAS_EXT_PIN(1'b0)) dut_nx (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_s), .bus_rd(rd_s),
    .bus_wdata(wdata), .bus_rdata(rdata_n), .cap_a_pin(cap_a), .cap_b_pin(cap_b),
    .ext_clk_pin(ext_p), .cmp_out(out_n));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: act=%0d exp<=190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_s = 1'b1;
    @(negedge clk); wr_s = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic [7:0] dn);
    @(negedge clk); addr = a; rd_s = 1'b1; #1; d = rdata; dn = rdata_n;
    @(negedge clk); rd_s = 1'b0;
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_p = 1'b1; idle(3);
      ext_p = 1'b0; idle(3);
    end
  endtask

  task automatic count_high(input int n, inout int hi, inout int mx);
    @(negedge clk); addr = 4'd11;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      hi += int'(out_m);
      if (int'(rdata) > mx) mx = int'(rdata);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d, dn;
    rd(4'd0, d, dn);  chk("R10 control readback after reset", d, 0);
    rd(4'd1, d, dn);  chk("R1 status after reset", d, 0);
    rd(4'd10, d, dn); chk("R1 count high after reset", d, 0);
    rd(4'd3, d, dn);  chk("R1 capture A low after reset", d, 0);
    chk("R1 cmp_out after reset", int'(out_m), 0);
  endtask

  task automatic t_prescale();
    logic [7:0] a, b, dn;
    int sel [3] = '{1, 0, 2};
    int exp [3] = '{20, 10, 5};
    for (int k = 0; k < 3; k++) begin
      wr(4'd0, 8'(sel[k] << 2));
      idle(4);
      rd(4'd11, a, dn);
      idle(38);
      rd(4'd11, b, dn);
      chk($sformatf("R2 ticks in 40 cycles sel=%0d", sel[k]), int'(8'(b - a)), exp[k]);
    end
  endtask

  task automatic t_ext();
    logic [7:0] a, b, an, bn;
    wr(4'd0, 8'h0D);
    idle(6);
    rd(4'd11, a, an);
    pulse_ext(5);
    idle(5);
    rd(4'd11, b, bn);
    chk("R3 rising external edges counted", int'(8'(b - a)), 5);
    chk("R3 counter holds without external pin", int'(8'(bn - an)), 0);
    wr(4'd0, 8'h0C);
    idle(6);
    rd(4'd11, a, an);
    pulse_ext(3);
    idle(5);
    rd(4'd11, b, bn);
    chk("R3 falling external edges counted", int'(8'(b - a)), 3);
  endtask

  task automatic t_capture();
    logic [7:0] c, h, d, dn;
    wr(4'd0, 8'h8C);
    idle(4);
    rd(4'd11, c, dn);
    rd(4'd10, h, dn);
    @(negedge clk); cap_a = 1'b1; idle(6);
    rd(4'd1, d, dn);  chk("R4 capture A flag set", int'(d[7]), 1);
    chk("R4 capture B flag still clear", int'(d[6]), 0);
    rd(4'd2, d, dn);  chk("R4 capture A high byte", d, h);
    rd(4'd3, d, dn);  chk("R4 capture A low byte", d, c);
    @(negedge clk); cap_b = 1'b1; idle(6);
    rd(4'd1, d, dn);  chk("R4 wrong-polarity edge on B ignored", int'(d[6]), 0);
    pulse_ext(2);
    @(negedge clk); cap_b = 1'b0; idle(6);
    rd(4'd1, d, dn);  chk("R4 capture B flag set on falling edge", int'(d[6]), 1);
    rd(4'd5, d, dn);  chk("R4 capture B low byte", d, 8'(c + 8'd2));
  endtask

  task automatic t_clear();
    logic [7:0] d, dn;
    @(negedge clk); cap_a = 1'b0; idle(6);
    @(negedge clk); cap_a = 1'b1; idle(6);
    rd(4'd3, d, dn);
    rd(4'd1, d, dn);  chk("R5 low access without status read keeps flag", int'(d[7]), 1);
    rd(4'd2, d, dn);
    rd(4'd1, d, dn);  chk("R5 high byte access keeps flag", int'(d[7]), 1);
    rd(4'd3, d, dn);
    rd(4'd1, d, dn);  chk("R5 status read then low read clears A", int'(d[7]), 0);
    @(negedge clk); cap_b = 1'b1; idle(4);
    @(negedge clk); cap_b = 1'b0; idle(6);
    rd(4'd1, d, dn);  chk("R5 flag B set before clear", int'(d[6]), 1);
    wr(4'd5, 8'h00);
    rd(4'd1, d, dn);  chk("R5 status read then low write clears B", int'(d[6]), 0);
  endtask

  task automatic t_pwm();
    logic [7:0] d, dn;
    int hi = 0, mx = 0;
    wr(4'd6, 8'h00); wr(4'd7, 8'd3);
    wr(4'd8, 8'h00); wr(4'd9, 8'd9);
    wr(4'd0, 8'h14);
    idle(30);
    count_high(200, hi, mx);
    chk("R7 high cycles over ten periods", hi, 60);
    chk("R7 peak count equals compare B", mx, 9);
    rd(4'd1, d, dn);  chk("R7 reload sets capture A flag", int'(d[7]), 1);
    wr(4'd0, 8'h34);
    idle(30);
    hi = 0; mx = 0;
    count_high(200, hi, mx);
    chk("R9 PWM wins over one-pulse: high cycles", hi, 60);
  endtask

  task automatic t_pulse();
    int hi = 0, mx = 0;
    wr(4'd7, 8'd20);
    @(negedge clk); cap_a = 1'b0;
    wr(4'd0, 8'hA4);
    idle(10);
    chk("R8 output idle before trigger", int'(out_m), 0);
    @(negedge clk); cap_a = 1'b1;
    count_high(100, hi, mx);
    chk_rng("R8 single pulse length", hi, 38, 42);
    chk("R8 output low after pulse", int'(out_m), 0);
    @(negedge clk); cap_a = 1'b0; idle(10);
    hi = 0;
    @(negedge clk); cap_a = 1'b1;
    count_high(15, hi, mx);
    cap_a = 1'b0;
    count_high(4, hi, mx);
    cap_a = 1'b1;
    count_high(130, hi, mx);
    chk_rng("R8 retrigger during pulse ignored", hi, 36, 42);
  endtask

  task automatic t_wrap();
    logic [7:0] d, dn;
    bit seen = 1'b0;
    wr(4'd0, 8'h04);
    rd(4'd1, d, dn);  chk("R6 wrap flag clear before wrap", int'(d[5]), 0);
    @(negedge clk); addr = 4'd1;
    for (int i = 0; i < 140000 && !seen; i++) begin
      @(negedge clk); #1;
      if (rdata[5]) seen = 1'b1;
    end
    chk("R6 wrap flag set after FFFF to 0000", int'(seen), 1);
    rd(4'd1, d, dn);
    rd(4'd3, d, dn);
    rd(4'd1, d, dn);  chk("R6 other low byte leaves wrap flag", int'(d[5]), 1);
    rd(4'd11, d, dn);
    rd(4'd1, d, dn);  chk("R6 count low access clears wrap flag", int'(d[5]), 0);
  endtask

  initial begin
    idle(5);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_ext();
    t_capture();
    t_clear();
    t_pwm();
    t_pulse();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule